// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block collects up to 32 interrupt request lines and folds them into one interrupt line toward a processor. Each line is fixed at build time as edge or level through a parameter mask. Captured requests go into a sticky status register. An enable register selects which captured requests count as pending. A priority encoder reports the lowest-numbered pending source as a vector.

Software drives the block through a small word-addressed bus. Each request carries a valid, a write flag, a byte address and a 32-bit write data word, and read data appears one cycle later. A two-bit master register carries two gates. Bit 0 gates the processor output. Bit 1 enables hardware capture of the request lines, and while it is set, software writes to the status register are locked out. Enable bits are changed with separate set and clear words, and status bits are cleared with an acknowledge word.

Top module: `irq_ctrl`

## Requirements
- R1: Register index is address bits [ADDR_W-1:2] (bits [1:0] ignored). Indices are 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. A read returns the register on `rsp_rdata_o` in the cycle after the request and returns zero in any cycle without a read. Reads at index 8 or above return zero, and writes there change nothing.
- R2: A write to the master register keeps only write data bits [1:0], and it reads back as those two bits.
- R3: A write to acknowledge clears each status bit where the data has a 1 and leaves the others.
- R4: A write to set-enable ORs the data into enable, a write to clear-enable clears enable bits where the data has a 1, and a write to enable loads it directly.
- R5: A write to status loads the data only while master bit 1 is 0. While master bit 1 is 1, such a write is ignored.
- R6: While master bit 1 is 1, a level source (mask bit 0) ORs its input into its status bit on every clock. The same-cycle capture wins over an acknowledge.
- R7: While master bit 1 is 1, an edge source (mask bit 1) sets its status bit on a low-to-high input transition, measured against a registered copy of the input. A source held high does not set the bit again after it is acknowledged. Status bits stay set until acknowledged or overwritten.
- R8: Pending reads as status AND enable at all times. Writes to pending or vector have no effect.
- R9: Vector reads as the index of the lowest-numbered pending bit, or 0xFFFFFFFF when none is pending.
- R10: `irq_o` is high exactly when master bit 0 is 1 and at least one pending bit is set. It follows the registers with no further delay.
- R11: After reset, status, enable, master and read data are zero, vector reads 0xFFFFFFFF and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | N_SRC | Interrupt request lines |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, one cycle after the read request |
| irq_o | output | 1 | Interrupt to processor |

## Verification
The bench builds the block with 32 sources, an 8-bit address and an edge mask of 0xA5A5_0F0F. With that mask, edge and level lines are interleaved at both nibble and byte granularity. Directed cases can therefore place an edge line (bit 2) and a level line (bit 4) inside the same byte, and the priority checks see mixed capture types next to each other. The 8-bit address lets the bench reach indices 8 through 63 for the out-of-map cases. The random phase sweeps every source type under all four master settings.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned REG_NUM = 8;

  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_PEND   = 3'd1,
    RG_ENABLE = 3'd2,
    RG_ACK    = 3'd3,
    RG_SETEN  = 3'd4,
    RG_CLREN  = 3'd5,
    RG_VECTOR = 3'd6,
    RG_MASTER = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int unsigned          N_SRC     = 32,
  parameter logic [N_SRC-1:0]     EDGE_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             arm_i,
  output logic [N_SRC-1:0] set_o
);
  logic [N_SRC-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      assign set_o[g] = arm_i & src_i[g] & ~src_q[g];
    end else begin : g_level
      assign set_o[g] = arm_i & src_i[g];
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned OUT_W = 32
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             any_o,
  output logic [OUT_W-1:0] idx_o
);
  logic [OUT_W-1:0] idx;

  // walk downward so the lowest set bit is the last one written
  always_comb begin
    idx = '1;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx = OUT_W'(i);
    end
  end

  assign any_o = |pend_i;
  assign idx_o = idx;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned      N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = N_SRC'(32'h0000_FFFF),
  parameter int unsigned      ADDR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [N_SRC-1:0]  stat_q, stat_d, en_q, en_d, pend, cap_set, wsrc;
  logic [1:0]        mer_q, mer_d;
  logic [DATA_W-1:0] vec_val, rd_val, rdata_q;
  logic [IDX_W-1:0]  idx;
  logic              in_map, pend_any;
  logic [REG_NUM-1:0] wr_hit;
  logic              unused_bits;

  assign idx    = req_addr_i[ADDR_W-1:2];
  assign in_map = idx < IDX_W'(REG_NUM);
  assign wsrc   = req_wdata_i[N_SRC-1:0];
  assign unused_bits = ^{req_addr_i[1:0], req_wdata_i};

  for (genvar k = 0; k < REG_NUM; k++) begin : g_dec
    assign wr_hit[k] = req_valid_i & req_write_i & in_map & (idx == IDX_W'(k));
  end

  irqc_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) i_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (irq_src_i),
    .arm_i  (mer_q[1]),
    .set_o  (cap_set)
  );

  assign pend = stat_q & en_q;

  irqc_prio #(.N_SRC(N_SRC), .OUT_W(DATA_W)) i_prio (
    .pend_i (pend),
    .any_o  (pend_any),
    .idx_o  (vec_val)
  );

  always_comb begin
    stat_d = stat_q;
    if (wr_hit[RG_STATUS] && !mer_q[1]) stat_d = wsrc;
    if (wr_hit[RG_ACK])                 stat_d = stat_d & ~wsrc;
    stat_d = stat_d | cap_set;  // capture wins over acknowledge
  end

  always_comb begin
    en_d = en_q;
    if (wr_hit[RG_ENABLE]) en_d = wsrc;
    if (wr_hit[RG_SETEN])  en_d = en_q | wsrc;
    if (wr_hit[RG_CLREN])  en_d = en_q & ~wsrc;
  end

  assign mer_d = wr_hit[RG_MASTER] ? req_wdata_i[1:0] : mer_q;

  always_comb begin
    unique case (idx[2:0])
      RG_STATUS: rd_val = DATA_W'(stat_q);
      RG_PEND:   rd_val = DATA_W'(pend);
      RG_ENABLE: rd_val = DATA_W'(en_q);
      RG_VECTOR: rd_val = vec_val;
      RG_MASTER: rd_val = DATA_W'(mer_q);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      en_q    <= '0;
      mer_q   <= '0;
      rdata_q <= '0;
    end else begin
      stat_q  <= stat_d;
      en_q    <= en_d;
      mer_q   <= mer_d;
      rdata_q <= (req_valid_i && !req_write_i && in_map) ? rd_val : '0;
    end
  end

  assign rsp_rdata_o = rdata_q;
  assign irq_o       = mer_q[0] & pend_any;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              irq_o,
  input logic [N_SRC-1:0]  stat_q,
  input logic [N_SRC-1:0]  en_q,
  input logic [1:0]        mer_q,
  input logic [N_SRC-1:0]  cap_set,
  input logic [DATA_W-1:0] vec_val
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] c_idx;
  logic [N_SRC-1:0] c_data;
  logic             c_wr, c_rd, c_map;

  assign c_idx  = req_addr_i[ADDR_W-1:2];
  assign c_map  = c_idx < IDX_W'(REG_NUM);
  assign c_wr   = req_valid_i & req_write_i & c_map;
  assign c_rd   = req_valid_i & ~req_write_i;
  assign c_data = req_wdata_i[N_SRC-1:0];

  assert_oor_read_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rd && !c_map) |=> (rsp_rdata_o == '0));

  assert_master_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && c_idx == IDX_W'(RG_MASTER)) |=> (mer_q == $past(req_wdata_i[1:0])));

  assert_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && c_idx == IDX_W'(RG_ACK)) |=> ((stat_q & $past(c_data) & ~$past(cap_set)) == '0));

  assert_set_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && c_idx == IDX_W'(RG_SETEN)) |=> ((en_q & $past(c_data)) == $past(c_data)));

  assert_clr_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && c_idx == IDX_W'(RG_CLREN)) |=> ((en_q & $past(c_data)) == '0));

  assert_status_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr && c_idx == IDX_W'(RG_STATUS) && mer_q[1]) |=> (stat_q == ($past(stat_q) | $past(cap_set))));

  assert_status_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_wr && (c_idx == IDX_W'(RG_ACK) || c_idx == IDX_W'(RG_STATUS)))
      |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_vector_none_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & en_q) == '0) |-> (vec_val == '1));

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mer_q[0] |-> !irq_o);
endmodule

bind irq_ctrl irqc_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) i_irqc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rsp_rdata_o (rsp_rdata_o),
  .irq_o       (irq_o),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .mer_q       (mer_q),
  .cap_set     (cap_set),
  .vec_val     (vec_val)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  localparam int          NS   = 32;
  localparam logic [31:0] MASK = 32'hA5A5_0F0F;

  logic        clk = 0, rst_n = 0;
  logic [31:0] src = '0;
  logic        valid = 0, write = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_ctrl #(.N_SRC(NS), .EDGE_MASK(MASK), .ADDR_W(8)) i_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .req_valid_i(valid),
    .req_write_i(write), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_stat, m_en, m_srcq, m_rdata;
  logic [1:0]  m_mer;

  function automatic logic [31:0] m_vec(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return i;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_reg(input int k);
    case (k)
      0: return m_stat;
      1: return m_stat & m_en;
      2: return m_en;
      6: return m_vec(m_stat & m_en);
      7: return {30'd0, m_mer};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_srcq = 0; m_rdata = 0; m_mer = 0;
    end else begin
      int k;
      logic [31:0] ns, ne;
      k = addr[7:2];
      m_rdata = (valid && !write && k < 8) ? m_reg(k) : 32'd0;
      ns = m_stat; ne = m_en;
      if (valid && write && k < 8) begin
        case (k)
          0: if (!m_mer[1]) ns = wdata;
          2: ne = wdata;
          3: ns = ns & ~wdata;
          4: ne = ne | wdata;
          5: ne = ne & ~wdata;
          default: ;
        endcase
      end
      if (m_mer[1])
        for (int i = 0; i < 32; i++)
          if (MASK[i] ? (src[i] && !m_srcq[i]) : src[i]) ns[i] = 1'b1;
      if (valid && write && k == 7) m_mer = wdata[1:0];
      m_stat = ns; m_en = ne; m_srcq = src;
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    n_chk += 2;
    if (irq !== (m_mer[0] && (m_stat & m_en) != 0)) begin
      n_err++;
      $display("FAIL R10 cycle irq act=%0b exp=%0b", irq, m_mer[0] && (m_stat & m_en) != 0);
    end
    if (rdata !== m_rdata) begin
      n_err++;
      $display("FAIL R1 cycle rdata act=%h exp=%h", rdata, m_rdata);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); valid = 1; write = 0; addr = a;
    @(negedge clk); valid = 0; d = rdata;
  endtask

  task automatic drive(input int b, input logic v);
    @(negedge clk); src[b] = v;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 irq", {31'd0, irq}, 0);
    chk("R11 rdata", rdata, 0);
    rd(8'h00, v); chk("R11 status", v, 0);
    rd(8'h08, v); chk("R11 enable", v, 0);
    rd(8'h18, v); chk("R11 vector", v, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R11 master", v, 0);
    // R2
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); chk("R2 master bits", v, 3);
    wr(8'h1C, 0);
    // R5 unlocked write, R4/R8/R9/R10
    wr(8'h00, 32'h30); rd(8'h00, v); chk("R5 status write", v, 32'h30);
    wr(8'h10, 32'h20); wr(8'h10, 32'h100);
    rd(8'h08, v); chk("R4 set-enable", v, 32'h120);
    rd(8'h04, v); chk("R8 pending", v, 32'h20);
    rd(8'h18, v); chk("R9 vector", v, 5);
    chk("R10 gated", {31'd0, irq}, 0);
    wr(8'h1C, 1); chk("R10 asserted", {31'd0, irq}, 1);
    wr(8'h04, 32'hFFFF); rd(8'h04, v); chk("R8 pending write ignored", v, 32'h20);
    wr(8'h18, 0); rd(8'h18, v); chk("R8 vector write ignored", v, 5);
    wr(8'h14, 32'h20); rd(8'h08, v); chk("R4 clear-enable", v, 32'h100);
    chk("R10 no pending", {31'd0, irq}, 0);
    wr(8'h08, 32'h30); rd(8'h08, v); chk("R4 direct enable", v, 32'h30);
    rd(8'h18, v); chk("R9 lowest first", v, 4);
    wr(8'h0C, 32'h10); rd(8'h00, v); chk("R3 ack", v, 32'h20);
    // R5 lock
    wr(8'h1C, 3); wr(8'h00, 32'hFFFF); rd(8'h00, v); chk("R5 status locked", v, 32'h20);
    // R6 level bit 4
    drive(4, 1); rd(8'h00, v); chk("R6 level capture", v, 32'h30);
    wr(8'h0C, 32'h10); rd(8'h00, v); chk("R6 level re-asserts", v, 32'h30);
    drive(4, 0); wr(8'h0C, 32'h10); rd(8'h00, v); chk("R6 level cleared", v, 32'h20);
    // R7 edge bit 2
    drive(2, 1); rd(8'h00, v); chk("R7 edge capture", v, 32'h24);
    wr(8'h0C, 32'h4); rd(8'h00, v); chk("R7 held high no re-set", v, 32'h20);
    drive(2, 0); drive(2, 1); rd(8'h00, v); chk("R7 second edge", v, 32'h24);
    // R9 priority
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h18, v); chk("R9 priority bit2", v, 2);
    wr(8'h0C, 32'h4); rd(8'h18, v); chk("R9 next bit5", v, 5);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h18, v); chk("R9 none pending", v, 32'hFFFF_FFFF);
    chk("R10 idle", {31'd0, irq}, 0);
    // R1 out of map
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk("R1 oor read", v, 0);
    rd(8'h00, v); chk("R1 oor write status", v, 0);
    rd(8'h08, v); chk("R1 oor write enable", v, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R1 oor write master", v, 3);
    // random phase, checked by the per-cycle model compare
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) src = $urandom;
      valid = $urandom_range(0, 1);
      write = $urandom_range(0, 1);
      addr  = 8'($urandom_range(0, 15) << 2);
      wdata = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
    end
    @(negedge clk); valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule